// File: doc/BRIEF.md
# Multi-cycle 8-bit processor core

This block is a small sequential processor that runs programs from one byte-wide synchronous memory. It has four 8-bit general registers, a 16-bit program counter, a 16-bit stack pointer, four condition flags and a halt bit. A state machine splits every instruction into single-byte memory transactions. These are the instruction fetch, the optional trailing address word, the data access and the stack pushes. The memory returns read data one clock after the read strobe.

Each instruction is a 16-bit word stored high byte first. It holds a 4-bit opcode, two 2-bit register selectors and an 8-bit immediate. Opcodes 0x0 to 0x9 are register-to-register arithmetic and logic. Opcodes 0xA to 0xE carry a second 16-bit word that holds an absolute address. Opcode 0xF stops the core. A counter of completed instructions lets the integrator measure program progress.

Top module: `cpu8_core`

## Requirements
- R1: Under reset the core holds pc = 0x0000, sp = 0xFFFE, flags = 0, halted = 0 and instr_count = 0. All registers are cleared.
- R2: The instruction word is formed from mem[pc] (bits 15:8) and mem[pc+1] (bits 7:0). Its fields are opcode = bits 15:12, rd = bits 11:10, rs = bits 9:8 and cond = bits 2:0. Opcodes without an address word advance pc by 2. All address arithmetic wraps modulo 65536.
- R3: The ALU opcodes write reg[rd] from A = reg[rd] and B = reg[rs]. The opcodes are 0 A+B, 1 A-B, 2 A AND B, 3 A OR B, 4 A XOR B, 5 A shifted left by one, 6 A shifted right by one, 7 the low byte of A*B, and 8 the quotient A/B. When B = 0, opcode 8 gives 0xFF.
- R4: The flags port is {Z,N,C,V} in bits 3..0. Opcodes 0 to 9 set Z when the result is zero and set N from result bit 7. For add, C is the carry out and V is signed overflow. For subtract and compare, C is 1 when A >= B and V is signed overflow. For every other ALU opcode, C and V are 0.
- R5: Opcode 9 (compare) sets the flags as a subtract does and writes no register.
- R6: Opcodes 0xA to 0xE read an address from mem[pc+2] (high byte) and mem[pc+3] (low byte). When they do not redirect, pc advances by 4.
- R7: Opcode 0xA loads reg[rd] from mem[addr]. It sets Z and N from the loaded byte and clears C and V.
- R8: Opcode 0xB writes reg[rs] to mem[addr] with exactly one write strobe. The flags are unchanged.
- R9: Opcode 0xC sets pc to addr.
- R10: Opcode 0xD sets pc to addr when its cond holds, otherwise to pc+4. The conds are 0 Z=1, 1 Z=0, 2 C=1, 3 C=0, 4 N=1, 5 N=0, 6 V=1, 7 V=0.
- R11: Opcode 0xE writes bits 15:8 of pc+4 to sp-1 and then bits 7:0 of pc+4 to sp-2. It leaves sp lowered by 2 and sets pc to addr. No other opcode changes sp.
- R12: Opcode 0xF sets halted and advances pc by 2. While halted, the core issues no memory strobe and changes no state.
- R13: instr_count rises by exactly one per completed instruction, halt included.
- R14: Each read returns data in the cycle after its strobe, and read and write strobes are never active together. An instruction takes 4 cycles without an address word and 6 cycles with one. Load takes 7 cycles and call takes 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 16 | Byte address of the current memory transaction |
| mem_rd | output | 1 | Read strobe; data is expected on mem_rdata one cycle later |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Registered read data from memory |
| halted | output | 1 | Core has executed a halt |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| flags | output | 4 | {Z,N,C,V} |
| instr_count | output | 16 | Completed instruction count |

## Verification
Architectural results settle within a fixed cycle budget per instruction: 4, 6, 7 or 8 cycles as R14 gives. A store's write strobe appears in the execute cycle, and a call's two pushes appear in the last two cycles of the call. The bench does not sample mid-instruction. It runs each short program until halted rises, reads pc, sp, flags, the count and the memory image on the falling edge, and checks the logged write order. One program is timed from reset release to halt to confirm the per-instruction cycle budget. A further idle window after halt confirms that nothing moves.

// File: rtl/cpu8_pkg.sv
// Package with the shared types of the 8-bit core.
// Assumes the 16-bit instruction format: opcode in the top nibble.
package cpu8_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'h0,
        OP_SUB  = 4'h1,
        OP_AND  = 4'h2,
        OP_OR   = 4'h3,
        OP_XOR  = 4'h4,
        OP_SHL  = 4'h5,
        OP_SHR  = 4'h6,
        OP_MUL  = 4'h7,
        OP_DIV  = 4'h8,
        OP_CMP  = 4'h9,
        OP_LD   = 4'hA,
        OP_ST   = 4'hB,
        OP_JMP  = 4'hC,
        OP_BR   = 4'hD,
        OP_CALL = 4'hE,
        OP_HLT  = 4'hF
    } op_e;

    typedef enum logic [3:0] {
        ST_FETCH_HI,
        ST_FETCH_LO,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_LATCH,
        ST_EXEC,
        ST_LOAD,
        ST_PUSH_HI,
        ST_PUSH_LO,
        ST_HALT
    } state_e;

    typedef struct packed {
        logic z;
        logic n;
        logic c;
        logic v;
    } flags_t;

    // True for the opcodes that carry a trailing address word
    function automatic logic needs_addr(input logic [3:0] opc);
        return (opc >= 4'hA) && (opc <= 4'hE);
    endfunction

endpackage

// File: rtl/cpu8_alu.sv
// Combinational ALU for opcodes 0x0..0x9.
// Produces the result byte and the four flags. Assumes W >= 2.
// The caller decides whether the result is written back.
module cpu8_alu
    import cpu8_pkg::*;
#(
    parameter int W = 8
) (
    input  op_e            op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y,
    output flags_t         fl
);

    logic [W:0] sum;
    logic [W:0] dif;

    assign sum = {1'b0, a} + {1'b0, b};
    assign dif = {1'b0, a} - {1'b0, b};

    // Result and carry/overflow selection per opcode
    always_comb begin
        y    = a;
        fl.c = 1'b0;
        fl.v = 1'b0;
        case (op)
            OP_ADD: begin
                y    = sum[W-1:0];
                fl.c = sum[W];
                fl.v = ~(a[W-1] ^ b[W-1]) & (a[W-1] ^ sum[W-1]);
            end
            OP_SUB, OP_CMP: begin
                y    = dif[W-1:0];
                fl.c = ~dif[W];
                fl.v = (a[W-1] ^ b[W-1]) & (a[W-1] ^ dif[W-1]);
            end
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_SHL:  y = {a[W-2:0], 1'b0};
            OP_SHR:  y = {1'b0, a[W-1:1]};
            OP_MUL:  y = a * b;
            OP_DIV:  y = (b == '0) ? '1 : a / b;
            default: y = a;
        endcase
        fl.z = (y == '0);
        fl.n = y[W-1];
    end

    // Result checks: sum undoes by subtraction, zero divisor saturates
    always_comb begin
        if (op == OP_ADD) begin
            p_add_inverse_r3: assert (W'(y - b) == a);
        end
        if (op == OP_DIV && b == '0) begin
            p_div_zero_sat_r3: assert (y == '1);
        end
    end

endmodule

// File: rtl/cpu8_cond.sv
// Branch condition evaluator.
// sel[2:1] picks the flag (0 Z, 1 C, 2 N, 3 V); sel[0] = 1 inverts it.
module cpu8_cond
    import cpu8_pkg::*;
(
    input  flags_t     fl,
    input  logic [2:0] sel,
    output logic       take
);

    logic picked;

    // Flag selection by the upper condition bits
    always_comb begin
        case (sel[2:1])
            2'd0:    picked = fl.z;
            2'd1:    picked = fl.c;
            2'd2:    picked = fl.n;
            default: picked = fl.v;
        endcase
    end

    assign take = sel[0] ? ~picked : picked;

endmodule

// File: rtl/cpu8_regfile.sv
// General register file: N registers of W bits.
// One synchronous write port, two asynchronous read ports.
// Synchronous active-low reset clears every register.
module cpu8_regfile #(
    parameter int W = 8,
    parameter int N = 4,
    localparam int SW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [SW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [SW-1:0] raddr_a,
    input  logic [SW-1:0] raddr_b,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b
);

    logic [W-1:0] regs [N];

    for (genvar g = 0; g < N; g++) begin : g_reg
        // One register with its own decoded write enable
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (we && waddr == SW'(g))
                regs[g] <= wdata;
        end
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];

endmodule

// File: rtl/cpu8_core.sv
// Multi-cycle 8-bit processor core (top).
// Drives a byte-wide memory with one-cycle read latency: a byte read
// strobed in cycle t is present on mem_rdata in cycle t+1.
// Each state issues at most one transaction and captures the byte
// requested by the previous state. Assumes DATA_W = 8, ADDR_W = 16, NREG = 4.
module cpu8_core
    import cpu8_pkg::*;
#(
    parameter int          DATA_W  = 8,
    parameter int          ADDR_W  = 16,
    parameter int          NREG    = 4,
    parameter int          CNT_W   = 16,
    parameter logic [15:0] SP_INIT = 16'hFFFE
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              halted,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] sp,
    output logic [3:0]        flags,
    output logic [CNT_W-1:0]  instr_count
);

    localparam int RSEL_W = $clog2(NREG);
    localparam int OPC_W  = 4;

    state_e              state_q;
    logic [ADDR_W-1:0]   pc_q;
    logic [ADDR_W-1:0]   sp_q;
    logic [DATA_W-1:0]   ir_hi_q;
    logic [2:0]          cond_q;
    logic [ADDR_W-1:0]   tgt_q;
    flags_t              flags_q;
    logic                halt_q;
    logic [CNT_W-1:0]    cnt_q;

    op_e                 op;
    logic [RSEL_W-1:0]   rd_sel;
    logic [RSEL_W-1:0]   rs_sel;
    logic [ADDR_W-1:0]   pc_p2;
    logic [ADDR_W-1:0]   pc_p4;
    logic [DATA_W-1:0]   opa;
    logic [DATA_W-1:0]   opb;
    logic [DATA_W-1:0]   alu_y;
    flags_t              alu_fl;
    logic                br_take;
    logic                rf_we;
    logic [DATA_W-1:0]   rf_wdata;

    assign op     = op_e'(ir_hi_q[DATA_W-1 -: OPC_W]);
    assign rd_sel = ir_hi_q[DATA_W-OPC_W-1 -: RSEL_W];
    assign rs_sel = ir_hi_q[DATA_W-OPC_W-RSEL_W-1 -: RSEL_W];
    assign pc_p2  = pc_q + ADDR_W'(2);
    assign pc_p4  = pc_q + ADDR_W'(4);

    cpu8_regfile #(.W(DATA_W), .N(NREG)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .waddr   (rd_sel),
        .wdata   (rf_wdata),
        .raddr_a (rd_sel),
        .raddr_b (rs_sel),
        .rdata_a (opa),
        .rdata_b (opb)
    );

    cpu8_alu #(.W(DATA_W)) u_alu (
        .op (op),
        .a  (opa),
        .b  (opb),
        .y  (alu_y),
        .fl (alu_fl)
    );

    cpu8_cond u_cond (
        .fl   (flags_q),
        .sel  (cond_q),
        .take (br_take)
    );

    // Register write-back: ALU results in execute, load data one state later
    always_comb begin
        rf_we    = (state_q == ST_EXEC && op <= OP_DIV) || (state_q == ST_LOAD);
        rf_wdata = (state_q == ST_LOAD) ? mem_rdata : alu_y;
    end

    // Memory transaction issued by the current state
    always_comb begin
        mem_addr  = '0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_wdata = '0;
        case (state_q)
            ST_FETCH_HI: begin mem_addr = pc_q;                  mem_rd = 1'b1; end
            ST_FETCH_LO: begin mem_addr = pc_q + ADDR_W'(1);     mem_rd = 1'b1; end
            ST_ADDR_HI:  begin mem_addr = pc_p2;                 mem_rd = 1'b1; end
            ST_ADDR_LO:  begin mem_addr = pc_q + ADDR_W'(3);     mem_rd = 1'b1; end
            ST_EXEC: begin
                if (op == OP_LD) begin
                    mem_addr = tgt_q;
                    mem_rd   = 1'b1;
                end else if (op == OP_ST) begin
                    mem_addr  = tgt_q;
                    mem_wr    = 1'b1;
                    mem_wdata = opb;
                end
            end
            ST_PUSH_HI: begin
                mem_addr  = sp_q - ADDR_W'(1);
                mem_wr    = 1'b1;
                mem_wdata = pc_p4[ADDR_W-1 -: DATA_W];
            end
            ST_PUSH_LO: begin
                mem_addr  = sp_q - ADDR_W'(1);
                mem_wr    = 1'b1;
                mem_wdata = pc_p4[DATA_W-1:0];
            end
            default: ;
        endcase
    end

    // Sequencer and architectural state update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FETCH_HI;
            pc_q    <= '0;
            sp_q    <= ADDR_W'(SP_INIT);
            ir_hi_q <= '0;
            cond_q  <= '0;
            tgt_q   <= '0;
            flags_q <= '0;
            halt_q  <= 1'b0;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_FETCH_HI: state_q <= ST_FETCH_LO;
                ST_FETCH_LO: begin
                    ir_hi_q <= mem_rdata;
                    state_q <= needs_addr(mem_rdata[DATA_W-1 -: OPC_W]) ? ST_ADDR_HI : ST_LATCH;
                end
                ST_ADDR_HI: begin
                    cond_q  <= mem_rdata[2:0];
                    state_q <= ST_ADDR_LO;
                end
                ST_ADDR_LO: begin
                    tgt_q[ADDR_W-1 -: DATA_W] <= mem_rdata;
                    state_q <= ST_LATCH;
                end
                ST_LATCH: begin
                    if (needs_addr(op))
                        tgt_q[DATA_W-1:0] <= mem_rdata;
                    else
                        cond_q <= mem_rdata[2:0];
                    state_q <= ST_EXEC;
                end
                ST_EXEC: begin
                    state_q <= ST_FETCH_HI;
                    if (op <= OP_CMP) begin
                        flags_q <= alu_fl;
                        pc_q    <= pc_p2;
                        cnt_q   <= cnt_q + 1'b1;
                    end else begin
                        case (op)
                            OP_LD:   state_q <= ST_LOAD;
                            OP_ST: begin
                                pc_q  <= pc_p4;
                                cnt_q <= cnt_q + 1'b1;
                            end
                            OP_JMP: begin
                                pc_q  <= tgt_q;
                                cnt_q <= cnt_q + 1'b1;
                            end
                            OP_BR: begin
                                pc_q  <= br_take ? tgt_q : pc_p4;
                                cnt_q <= cnt_q + 1'b1;
                            end
                            OP_CALL: state_q <= ST_PUSH_HI;
                            default: begin
                                halt_q  <= 1'b1;
                                pc_q    <= pc_p2;
                                cnt_q   <= cnt_q + 1'b1;
                                state_q <= ST_HALT;
                            end
                        endcase
                    end
                end
                ST_LOAD: begin
                    flags_q <= '{z: (mem_rdata == '0), n: mem_rdata[DATA_W-1], c: 1'b0, v: 1'b0};
                    pc_q    <= pc_p4;
                    cnt_q   <= cnt_q + 1'b1;
                    state_q <= ST_FETCH_HI;
                end
                ST_PUSH_HI: begin
                    sp_q    <= sp_q - ADDR_W'(1);
                    state_q <= ST_PUSH_LO;
                end
                ST_PUSH_LO: begin
                    sp_q    <= sp_q - ADDR_W'(1);
                    pc_q    <= tgt_q;
                    cnt_q   <= cnt_q + 1'b1;
                    state_q <= ST_FETCH_HI;
                end
                default: state_q <= ST_HALT;
            endcase
        end
    end

    assign halted      = halt_q;
    assign pc          = pc_q;
    assign sp          = sp_q;
    assign flags       = flags_q;
    assign instr_count = cnt_q;

    // R12: a halted core is silent on the memory bus
    p_halt_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_rd && !mem_wr));

    // R12: a halted core keeps every visible register
    p_halt_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(pc) && $stable(sp) && $stable(flags) && $stable(instr_count)));

    // R14: read and write never share a cycle
    p_no_rw_clash_r14: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R2: the second instruction byte is read from the next address
    p_fetch_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH_HI) |=> (mem_rd && mem_addr == $past(mem_addr) + ADDR_W'(1)));

    // R13: the counter never moves by more than one per cycle
    p_count_step_r13: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (instr_count == $past(instr_count) || instr_count == $past(instr_count) + 1'b1));

    // R11: the low push lands one byte below the high push
    p_push_pair_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PUSH_HI) |=> (mem_wr && mem_addr == $past(mem_addr) - ADDR_W'(1)));

    // R11: sp only moves during the call pushes
    p_sp_call_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_PUSH_HI && state_q != ST_PUSH_LO) |=> $stable(sp));

    // R8: flags survive store, jump, branch, call and halt
    p_flags_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXEC && op >= OP_ST) |=> $stable(flags));

endmodule

// File: tb/tb_cpu8_core.sv
module tb_cpu8_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic        mem_wr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;
    logic        halted;
    logic [15:0] pc;
    logic [15:0] sp;
    logic [3:0]  flags;
    logic [15:0] instr_count;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    cpu8_core dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .mem_addr    (mem_addr),
        .mem_rd      (mem_rd),
        .mem_wr      (mem_wr),
        .mem_wdata   (mem_wdata),
        .mem_rdata   (mem_rdata),
        .halted      (halted),
        .pc          (pc),
        .sp          (sp),
        .flags       (flags),
        .instr_count (instr_count)
    );

    // 4 KiB memory model, aliased over the 64 KiB space, one-cycle read
    logic [7:0]  mem [0:4095];
    logic [15:0] wl_addr [0:7];
    logic [7:0]  wl_data [0:7];
    int          wcount = 0;
    int          quiet_bad = 0;

    always @(posedge clk) begin
        if (mem_wr) begin
            mem[mem_addr[11:0]] <= mem_wdata;
            if (wcount < 8) begin
                wl_addr[wcount] <= mem_addr;
                wl_data[wcount] <= mem_wdata;
            end
            wcount <= wcount + 1;
        end
        if (mem_rd) mem_rdata <= mem[mem_addr[11:0]];
        if (rst_n && halted && (mem_rd || mem_wr)) quiet_bad <= quiet_bad + 1;
    end

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] enc(input int op, input int rd, input int rs, input int imm);
        return {op[3:0], rd[1:0], rs[1:0], imm[7:0]};
    endfunction

    task automatic put16(input logic [15:0] a, input logic [15:0] v);
        mem[a[11:0]] = v[15:8];
        mem[12'(a[11:0] + 12'd1)] = v[7:0];
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    endtask

    function automatic logic [7:0] rd_mem(input logic [15:0] a);
        return mem[a[11:0]];
    endfunction

    // Reset, release, run until halted; cyc = number of cycles executed
    task automatic run_prog(output int cyc);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        wcount    = 0;
        quiet_bad = 0;
        rst_n     = 1'b1;
        cyc = 0;
        while (!halted && cyc < 3000) begin
            cyc++;
            @(negedge clk);
        end
        if (!halted) begin
            checks++;
            errors++;
            $display("FAIL R12 program did not halt: actual 0 expected 1");
        end
    endtask

    // Expected ALU result and flags {Z,N,C,V}
    function automatic void exp_alu(input int op, input logic [7:0] a, input logic [7:0] b,
                                    output logic [7:0] r, output logic [3:0] f);
        logic       c;
        logic       v;
        logic [8:0] s;
        logic [15:0] p;
        c = 1'b0;
        v = 1'b0;
        s = {1'b0, a} + {1'b0, b};
        p = {8'h00, a} * {8'h00, b};
        case (op)
            0: begin r = s[7:0]; c = s[8]; v = (a[7] == b[7]) && (r[7] != a[7]); end
            1, 9: begin r = a - b; c = (a >= b); v = (a[7] != b[7]) && (r[7] != a[7]); end
            2: r = a & b;
            3: r = a | b;
            4: r = a ^ b;
            5: r = {a[6:0], 1'b0};
            6: r = {1'b0, a[7:1]};
            7: r = p[7:0];
            8: r = (b == 8'h00) ? 8'hFF : a / b;
            default: r = a;
        endcase
        f = {(r == 8'h00), r[7], c, v};
    endfunction

    // load rd, load rs, op, store rd to 0x0302, halt
    task automatic alu_case(input int op, input int rdi, input int rsi, input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r;
        logic [3:0] f;
        int         cyc;
        string      rtag;
        clear_mem();
        put16(16'h0000, enc(10, rdi, 0, 0));  put16(16'h0002, 16'h0300);
        put16(16'h0004, enc(10, rsi, 0, 0));  put16(16'h0006, 16'h0301);
        put16(16'h0008, enc(op, rdi, rsi, 0));
        put16(16'h000A, enc(11, 0, rdi, 0));  put16(16'h000C, 16'h0302);
        put16(16'h000E, enc(15, 0, 0, 0));
        mem[12'h300] = a;
        mem[12'h301] = b;
        run_prog(cyc);
        exp_alu(op, a, b, r, f);
        rtag = (op == 9) ? "R5" : "R3";
        chk(rtag, $sformatf("op %0d stored byte", op), rd_mem(16'h0302), (op == 9) ? a : r);
        chk("R4", $sformatf("op %0d flags", op), flags, f);
        chk("R8", "single store strobe", wcount, 1);
        chk("R13", "instruction count", instr_count, 5);
        chk("R2", "final pc", pc, 16'h0010);
    endtask

    // cmp a,b then branch with cond; taken -> halt at 0x40, else halt at 0x0E
    task automatic br_case(input logic [7:0] a, input logic [7:0] b, input int cond);
        logic [7:0] r;
        logic [3:0] f;
        logic       take;
        int         cyc;
        clear_mem();
        put16(16'h0000, enc(10, 0, 0, 0));   put16(16'h0002, 16'h0300);
        put16(16'h0004, enc(10, 1, 0, 0));   put16(16'h0006, 16'h0301);
        put16(16'h0008, enc(9, 0, 1, 0));
        put16(16'h000A, enc(13, 0, 0, cond)); put16(16'h000C, 16'h0040);
        put16(16'h000E, enc(15, 0, 0, 0));
        put16(16'h0040, enc(15, 0, 0, 0));
        mem[12'h300] = a;
        mem[12'h301] = b;
        run_prog(cyc);
        exp_alu(9, a, b, r, f);
        case (cond)
            0: take = f[3];
            1: take = !f[3];
            2: take = f[1];
            3: take = !f[1];
            4: take = f[2];
            5: take = !f[2];
            6: take = f[0];
            default: take = !f[0];
        endcase
        chk("R10", $sformatf("cond %0d a %0h b %0h pc", cond, a, b), pc, take ? 16'h0042 : 16'h0010);
    endtask

    initial begin
        int cyc;
        logic [15:0] pc_hold;
        logic [15:0] cnt_hold;
        void'($urandom(32'h5EED_0C0E));
        clear_mem();
        put16(16'h0000, enc(15, 0, 0, 0));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "pc in reset", pc, 16'h0000);
        chk("R1", "sp in reset", sp, 16'hFFFE);
        chk("R1", "flags in reset", flags, 4'h0);
        chk("R1", "halted in reset", halted, 1'b0);
        chk("R1", "count in reset", instr_count, 16'h0000);

        // Reference program: 5 + 7 stored at 0x0102, timed end to end
        clear_mem();
        put16(16'h0000, enc(10, 0, 0, 0)); put16(16'h0002, 16'h0100);
        put16(16'h0004, enc(10, 1, 0, 0)); put16(16'h0006, 16'h0101);
        put16(16'h0008, enc(0, 0, 1, 0));
        put16(16'h000A, enc(11, 0, 0, 0)); put16(16'h000C, 16'h0102);
        put16(16'h000E, enc(15, 0, 0, 0));
        mem[12'h100] = 8'd5;
        mem[12'h101] = 8'd7;
        run_prog(cyc);
        chk("R7", "sum stored", rd_mem(16'h0102), 8'd12);
        chk("R13", "five instructions", instr_count, 16'd5);
        chk("R14", "cycles 7+7+4+6+4", cyc, 28);
        chk("R6", "pc after halt", pc, 16'h0010);
        chk("R12", "halted raised", halted, 1'b1);
        chk("R1", "sp untouched", sp, 16'hFFFE);

        // Halt freeze window
        pc_hold  = pc;
        cnt_hold = instr_count;
        repeat (20) @(negedge clk);
        chk("R12", "pc frozen", pc, pc_hold);
        chk("R12", "count frozen", instr_count, cnt_hold);
        chk("R12", "no strobes while halted", quiet_bad, 0);

        // Directed ALU corners
        alu_case(0, 0, 1, 8'hFF, 8'h01);
        alu_case(0, 2, 3, 8'h7F, 8'h01);
        alu_case(1, 1, 0, 8'h00, 8'h01);
        alu_case(1, 3, 2, 8'h80, 8'h01);
        alu_case(8, 0, 2, 8'h07, 8'h00);
        alu_case(8, 1, 3, 8'hC8, 8'h07);
        alu_case(7, 2, 0, 8'h10, 8'h11);
        alu_case(5, 3, 1, 8'h81, 8'h00);
        alu_case(6, 0, 3, 8'h01, 8'h00);
        alu_case(4, 1, 2, 8'h5A, 8'h5A);
        alu_case(9, 2, 1, 8'h33, 8'h33);

        // Random ALU stimulus
        for (int i = 0; i < 40; i++) begin
            int op, rdi, rsi;
            logic [7:0] a, b;
            op  = $urandom % 10;
            rdi = $urandom % 4;
            rsi = (rdi + 1 + ($urandom % 3)) % 4;
            a   = 8'($urandom);
            b   = (($urandom % 5) == 0) ? 8'h00 : 8'($urandom);
            alu_case(op, rdi, rsi, a, b);
        end

        // Branch conditions over three flag patterns
        for (int c = 0; c < 8; c++) begin
            br_case(8'h05, 8'h05, c);
            br_case(8'h80, 8'h01, c);
            br_case(8'h7F, 8'hFF, c);
        end

        // Load flags override an earlier C=1,V=1
        for (int k = 0; k < 3; k++) begin
            logic [7:0] val;
            val = (k == 0) ? 8'h00 : ((k == 1) ? 8'h80 : 8'h41);
            clear_mem();
            put16(16'h0000, enc(10, 0, 0, 0)); put16(16'h0002, 16'h0300);
            put16(16'h0004, enc(10, 1, 0, 0)); put16(16'h0006, 16'h0301);
            put16(16'h0008, enc(9, 0, 1, 0));
            put16(16'h000A, enc(10, 3, 0, 0)); put16(16'h000C, 16'h0302);
            put16(16'h000E, enc(11, 0, 3, 0)); put16(16'h0010, 16'h0303);
            put16(16'h0012, enc(15, 0, 0, 0));
            mem[12'h300] = 8'h80;
            mem[12'h301] = 8'h01;
            mem[12'h302] = val;
            mem[12'h303] = 8'hEE;
            run_prog(cyc);
            chk("R7", "loaded byte stored back", rd_mem(16'h0303), val);
            chk("R7", "load flags", flags, {(val == 8'h00), val[7], 2'b00});
        end

        // Plain jump
        clear_mem();
        put16(16'h0000, enc(12, 0, 0, 0)); put16(16'h0002, 16'h0040);
        put16(16'h0004, enc(15, 0, 0, 0));
        put16(16'h0040, enc(15, 0, 0, 0));
        run_prog(cyc);
        chk("R9", "jump target reached", pc, 16'h0042);
        chk("R9", "jump count", instr_count, 16'd2);
        chk("R14", "cycles 6+4", cyc, 10);

        // Jump to odd address, call with nontrivial return address
        clear_mem();
        put16(16'h0000, enc(12, 0, 0, 0)); put16(16'h0002, 16'h0123);
        put16(16'h0123, enc(14, 0, 0, 0)); put16(16'h0125, 16'h0200);
        put16(16'h0200, enc(15, 0, 0, 0));
        run_prog(cyc);
        chk("R11", "two pushes", wcount, 2);
        chk("R11", "first push address", wl_addr[0], 16'hFFFD);
        chk("R11", "first push data", wl_data[0], 8'h01);
        chk("R11", "second push address", wl_addr[1], 16'hFFFC);
        chk("R11", "second push data", wl_data[1], 8'h27);
        chk("R11", "sp after call", sp, 16'hFFFC);
        chk("R11", "pc after call and halt", pc, 16'h0202);
        chk("R14", "cycles 6+8+4", cyc, 18);

        // pc wrap: branch not taken, jump to 0xFFFE, xor wraps to 0, branch taken
        clear_mem();
        put16(16'h0000, enc(13, 0, 0, 0)); put16(16'h0002, 16'h0010);
        put16(16'h0004, enc(12, 0, 0, 0)); put16(16'h0006, 16'hFFFE);
        put16(16'hFFFE, enc(4, 0, 0, 0));
        put16(16'h0010, enc(15, 0, 0, 0));
        run_prog(cyc);
        chk("R2", "wrap path pc", pc, 16'h0012);
        chk("R2", "wrap path count", instr_count, 16'd5);
        chk("R4", "xor zero flags", flags, 4'b1000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule